// File: doc/BRIEF.md
# Register Write-Lock Protection Unit

This block guards the register file of a real-time-clock style peripheral. It has a lock register whose bits decide whether writes to the control register, the status register and the lock register itself take effect. Software can only clear a lock bit. Once a bit is cleared, only a reset sets it again, and the two reset sources restore different sets of bits. The block also keeps a time-invalid flag. This flag forces the seconds and prescaler values to read as zero until software writes a fresh seconds value while the counter is stopped.

The register bus is a simple synchronous one. A write happens on the rising clock edge when the write enable is high. Read data is a combinational function of the address and the current register state. Power-on reset and software reset are both synchronous and active-high. Power-on reset wins when both are high in the same cycle. The time counters are not modelled. Only their stored values, the counter-enable bit and the seconds-write strobe are kept.

Top module: `rtc_wlock_guard`

## Requirements
- R1: Power-on reset sets every register to its reset value: lock register 0x0000_00FF, status 0x0000_0001 (invalid flag set, counter disabled), control 0, seconds 0 and prescaler 0.
- R2: The lock register always reads 0 in bits 31..8 and 1 in bit 7, whatever was written.
- R3: Each lock bit is 1 for unlocked and 0 for locked. Lock bit 6 guards the lock register, bit 5 guards the status register and bit 4 guards the control register. A write to a locked register leaves its contents unchanged.
- R4: A write to an unlocked lock register clears every bit 6..0 that is written as 0. A bit written as 1 keeps its current value, so software can never set a lock bit. Bits 3..0 follow the same rule.
- R5: Software reset sets lock bits 6, 5 and 3..0 to 1 and leaves lock bit 4 and the control register unchanged. It clears the seconds, prescaler and counter-enable values.
- R6: Power-on reset sets all lock bits 6..0 to 1, including bit 4, and takes priority over a software reset in the same cycle.
- R7: Power-on reset and software reset both set the time-invalid flag. While the flag is set, the seconds and prescaler addresses read as zero.
- R8: A seconds write clears the time-invalid flag only when the counter is disabled and status lock bit 5 is 1. A seconds write in any other case leaves the flag set.
- R9: Address map, using word addresses: 0 is seconds (32 bits), 1 is prescaler (16 bits), 2 is control (8 bits), 3 is status and 4 is the lock register. In the status register, bit 0 is the read-only invalid flag and bit 4 is the counter enable. Unmapped addresses read 0.
- R10: Writes to the seconds and prescaler registers take effect only while the counter enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active-high |
| swr_i | input | 1 | Software reset, synchronous, active-high |
| adr_i | input | ADDR_W (3) | Register word address |
| we_i | input | 1 | Write enable |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, combinational |

## Verification
The assertions check on every cycle that no lock bit ever rises except through a reset, and that software reset alone never changes the control lock bit. They also check that power-on reset restores every lock bit, that locked control, status and lock registers hold their contents across writes, and that the invalid flag falls only on a qualifying seconds write. Other behaviours show only in the bench's scenarios. These are the constant reserved bits as seen on the bus, the zero read-out while the flag is set, and ignored seconds writes while the counter runs. The same applies to the exact set of bits each reset source restores, and to a lock register that has locked itself and then receives a software reset.

// File: rtl/rtc_wlock_pkg.sv
package rtc_wlock_pkg;
  localparam int LOCK_W = 7;
  localparam int LK_SELF = 6;
  localparam int LK_STAT = 5;
  localparam int LK_CTRL = 4;
  localparam int ST_INV = 0;
  localparam int ST_CEN = 4;

  localparam int SEC_ADR = 0;
  localparam int PRE_ADR = 1;
  localparam int CTL_ADR = 2;
  localparam int STA_ADR = 3;
  localparam int LCK_ADR = 4;

  // bits that software reset brings back to 1 (all but the control lock)
  localparam logic [LOCK_W-1:0] SWR_SET = ~(LOCK_W'(1) << LK_CTRL);

  function automatic logic [LOCK_W-1:0] lock_clear(input logic [LOCK_W-1:0] cur,
                                                   input logic [LOCK_W-1:0] wd);
    return cur & wd;
  endfunction

  function automatic logic [LOCK_W-1:0] lock_after_swr(input logic [LOCK_W-1:0] cur);
    return cur | SWR_SET;
  endfunction

  function automatic logic [31:0] lock_view(input logic [LOCK_W-1:0] lk);
    return {24'h0, 1'b1, lk};
  endfunction
endpackage

// File: rtl/rtc_lock_bits.sv
module rtc_lock_bits
  import rtc_wlock_pkg::*;
(
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              swr_i,
  input  logic              wr_i,
  input  logic [LOCK_W-1:0] wd_i,
  output logic [LOCK_W-1:0] lk_o
);
  logic [LOCK_W-1:0] lk_q;
  logic              lk_wr_ok;

  assign lk_wr_ok = wr_i & lk_q[LK_SELF];
  assign lk_o     = lk_q;

  always_ff @(posedge clk_i) begin
    if (por_i)         lk_q <= '1;
    else if (swr_i)    lk_q <= lock_after_swr(lk_q);
    else if (lk_wr_ok) lk_q <= lock_clear(lk_q, wd_i);
  end

  assert_no_self_set_R4: assert property (@(posedge clk_i) disable iff (por_i)
    !swr_i |=> ((lk_q & ~$past(lk_q)) == '0));
  assert_swr_keeps_ctl_R5: assert property (@(posedge clk_i) disable iff (por_i)
    swr_i |=> (lk_q[LK_CTRL] == $past(lk_q[LK_CTRL])));
  assert_por_restores_R6: assert property (@(posedge clk_i)
    por_i |=> (lk_q == '1));
  assert_lock_locked_R3: assert property (@(posedge clk_i) disable iff (por_i)
    (wr_i && !lk_q[LK_SELF] && !swr_i) |=> $stable(lk_q));
endmodule

// File: rtl/rtc_ctl_store.sv
module rtc_ctl_store #(
  parameter int CTL_W = 8
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             wr_i,
  input  logic             unl_i,
  input  logic [CTL_W-1:0] wd_i,
  output logic [CTL_W-1:0] ctl_o
);
  logic [CTL_W-1:0] ctl_q;
  logic             ctl_wr_ok;

  assign ctl_wr_ok = wr_i & unl_i;
  assign ctl_o     = ctl_q;

  always_ff @(posedge clk_i) begin
    if (por_i)          ctl_q <= '0;
    else if (ctl_wr_ok) ctl_q <= wd_i;
  end

  assert_ctl_locked_R3: assert property (@(posedge clk_i) disable iff (por_i)
    (wr_i && !unl_i) |=> $stable(ctl_q));
endmodule

// File: rtl/rtc_time_state.sv
module rtc_time_state
  import rtc_wlock_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int PRE_W = 16
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             swr_i,
  input  logic             sec_wr_i,
  input  logic             pre_wr_i,
  input  logic             sta_wr_i,
  input  logic             sta_unl_i,
  input  logic [SEC_W-1:0] wd_i,
  output logic [SEC_W-1:0] sec_rd_o,
  output logic [PRE_W-1:0] pre_rd_o,
  output logic             inval_o,
  output logic             cen_o
);
  logic [SEC_W-1:0] sec_q;
  logic [PRE_W-1:0] pre_q;
  logic             inval_q, cen_q;
  logic             clr_ev, sec_ld, pre_ld, cen_ld;

  assign clr_ev = sec_wr_i & ~cen_q & sta_unl_i;
  assign sec_ld = sec_wr_i & ~cen_q;
  assign pre_ld = pre_wr_i & ~cen_q;
  assign cen_ld = sta_wr_i & sta_unl_i;

  always_ff @(posedge clk_i) begin
    if (por_i || swr_i) begin
      sec_q   <= '0;
      pre_q   <= '0;
      inval_q <= 1'b1;
      cen_q   <= 1'b0;
    end else begin
      if (sec_ld) sec_q   <= wd_i;
      if (pre_ld) pre_q   <= wd_i[PRE_W-1:0];
      if (clr_ev) inval_q <= 1'b0;
      if (cen_ld) cen_q   <= wd_i[ST_CEN];
    end
  end

  assign sec_rd_o = inval_q ? '0 : sec_q;
  assign pre_rd_o = inval_q ? '0 : pre_q;
  assign inval_o  = inval_q;
  assign cen_o    = cen_q;

  assert_inval_clear_R8: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(inval_q) |-> $past(sec_wr_i && !cen_q && sta_unl_i));
  assert_reset_inval_R7: assert property (@(posedge clk_i)
    (por_i || swr_i) |=> inval_q);
  assert_sta_locked_R3: assert property (@(posedge clk_i) disable iff (por_i)
    (sta_wr_i && !sta_unl_i && !swr_i) |=> $stable(cen_q));
endmodule

// File: rtl/rtc_wlock_guard.sv
module rtc_wlock_guard
  import rtc_wlock_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 16,
  parameter int CTL_W  = 8
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              swr_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic              sec_wr, pre_wr, ctl_wr, sta_wr, lck_wr;
  logic [LOCK_W-1:0] lk;
  logic [CTL_W-1:0]  ctl;
  logic [DATA_W-1:0] sec_rd;
  logic [PRE_W-1:0]  pre_rd;
  logic              inval, cen;

  assign sec_wr = we_i && (adr_i == ADDR_W'(SEC_ADR));
  assign pre_wr = we_i && (adr_i == ADDR_W'(PRE_ADR));
  assign ctl_wr = we_i && (adr_i == ADDR_W'(CTL_ADR));
  assign sta_wr = we_i && (adr_i == ADDR_W'(STA_ADR));
  assign lck_wr = we_i && (adr_i == ADDR_W'(LCK_ADR));

  rtc_lock_bits u_lock (
    .clk_i(clk_i), .por_i(por_i), .swr_i(swr_i),
    .wr_i(lck_wr), .wd_i(wdata_i[LOCK_W-1:0]), .lk_o(lk)
  );

  rtc_ctl_store #(.CTL_W(CTL_W)) u_ctl (
    .clk_i(clk_i), .por_i(por_i), .wr_i(ctl_wr),
    .unl_i(lk[LK_CTRL]), .wd_i(wdata_i[CTL_W-1:0]), .ctl_o(ctl)
  );

  rtc_time_state #(.SEC_W(DATA_W), .PRE_W(PRE_W)) u_time (
    .clk_i(clk_i), .por_i(por_i), .swr_i(swr_i),
    .sec_wr_i(sec_wr), .pre_wr_i(pre_wr), .sta_wr_i(sta_wr),
    .sta_unl_i(lk[LK_STAT]), .wd_i(wdata_i),
    .sec_rd_o(sec_rd), .pre_rd_o(pre_rd), .inval_o(inval), .cen_o(cen)
  );

  always_comb begin
    rdata_o = '0;
    case (adr_i)
      ADDR_W'(SEC_ADR): rdata_o = sec_rd;
      ADDR_W'(PRE_ADR): rdata_o = DATA_W'(pre_rd);
      ADDR_W'(CTL_ADR): rdata_o = DATA_W'(ctl);
      ADDR_W'(STA_ADR): begin
        rdata_o[ST_INV] = inval;
        rdata_o[ST_CEN] = cen;
      end
      ADDR_W'(LCK_ADR): rdata_o = DATA_W'(lock_view(lk));
      default:          rdata_o = '0;
    endcase
  end
endmodule

// File: tb/tb_rtc_wlock_guard.sv
`timescale 1ns/100ps
module tb_rtc_wlock_guard;
  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        swr = 1'b0;
  logic [2:0]  adr = '0;
  logic        we  = 1'b0;
  logic [31:0] wd  = '0;
  logic [31:0] rd;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model of the register state
  logic [6:0]  m_lk;
  logic [7:0]  m_ctl;
  logic [31:0] m_sec;
  logic [15:0] m_pre;
  logic        m_inv, m_cen;

  always #2.5 clk = ~clk;

  rtc_wlock_guard dut (
    .clk_i(clk), .por_i(por), .swr_i(swr), .adr_i(adr),
    .we_i(we), .wdata_i(wd), .rdata_o(rd)
  );

  function automatic logic [31:0] expect_rd(input int a);
    case (a)
      0: return m_inv ? 32'h0 : m_sec;
      1: return m_inv ? 32'h0 : {16'h0, m_pre};
      2: return {24'h0, m_ctl};
      3: return {27'h0, m_cen, 3'b000, m_inv};
      4: return {24'h0, 1'b1, m_lk};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_edge(input bit p, input bit s, input bit w,
                            input int a, input logic [31:0] d);
    if (p) begin
      m_lk = 7'h7F; m_ctl = 8'h00;
      m_sec = '0; m_pre = '0; m_inv = 1'b1; m_cen = 1'b0;
    end else if (s) begin
      m_lk = m_lk | 7'b1101111;
      m_sec = '0; m_pre = '0; m_inv = 1'b1; m_cen = 1'b0;
    end else if (w) begin
      case (a)
        0: if (!m_cen) begin
             m_sec = d;
             if (m_lk[5]) m_inv = 1'b0;
           end
        1: if (!m_cen) m_pre = d[15:0];
        2: if (m_lk[4]) m_ctl = d[7:0];
        3: if (m_lk[5]) m_cen = d[4];
        4: if (m_lk[6]) m_lk = m_lk & d[6:0];
        default: ;
      endcase
    end
  endtask

  task automatic cycle(input bit p, input bit s, input bit w,
                       input int a, input logic [31:0] d);
    @(negedge clk);
    por = p; swr = s; we = w; adr = a[2:0]; wd = d;
    @(posedge clk);
    model_edge(p, s, w, a, d);
    @(negedge clk);
    por = 0; swr = 0; we = 0;
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 8; a++) begin
      adr = a[2:0];
      #0.5;
      total++;
      if (rd !== expect_rd(a)) begin
        bad++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rd, expect_rd(a));
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    model_edge(1, 0, 0, 0, 0);
    cycle(1, 0, 0, 0, 0);
    check_all("R1 R9 reset state and map");
    cycle(0, 0, 1, 4, 32'h0000_FF00);          // clear bits 6..0? no: bits 7..0 zero -> clears all
    check_all("R2 R4 lock cleared, bit7 still 1");
    cycle(0, 0, 1, 4, 32'hFFFF_FFFF);
    check_all("R3 R4 self-locked lock ignores ones");
    cycle(0, 0, 1, 2, 32'h0000_0011);
    check_all("R3 control locked");
    cycle(0, 1, 0, 0, 0);
    check_all("R5 swr restores all but control lock");
    cycle(1, 1, 0, 0, 0);
    check_all("R6 por wins over swr");
    cycle(0, 0, 1, 2, 32'h0000_005A);
    cycle(0, 0, 1, 0, 32'd123);
    check_all("R8 R9 seconds write clears flag");
    cycle(0, 0, 1, 1, 32'hABCD_1234);
    cycle(0, 0, 1, 3, 32'h0000_0010);
    cycle(0, 0, 1, 0, 32'd7);
    cycle(0, 0, 1, 1, 32'h0000_0042);
    check_all("R10 writes ignored while counter runs");
    cycle(0, 1, 0, 0, 0);
    check_all("R5 R7 swr keeps control, sets flag");
    cycle(0, 0, 1, 4, 32'hFFFF_FFDF);
    cycle(0, 0, 1, 0, 32'd9);
    check_all("R8 status locked keeps flag");
    cycle(0, 0, 1, 3, 32'h0000_0010);
    cycle(0, 0, 1, 4, 32'h0000_00FF);
    check_all("R3 R4 status locked, no re-set");
    cycle(0, 0, 1, 4, 32'h0000_007D);
    check_all("R4 low lock bits clear-only");
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 63);
      cycle(r == 0, r == 1 || r == 2, r > 2, $urandom_range(0, 7), $urandom());
      check_all("R1-R10 random");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule